// File: doc/BRIEF.md
# Two-Wire Slave Address Pointer Manager

This block holds the address state that sits behind a two-wire serial slave serving two logical targets. One target is a byte-addressed memory. The other is a small bank of control registers. The bus controller reports events at byte level: a transaction start with its target and direction, an address byte received, a data byte completed, and a stop. This block decides which bytes load which pointer. It keeps a memory pointer that persists across transactions and a register pointer with a hard range check. It presents the active address together with a valid flag and an illegal flag. The bus side uses the illegal flag to refuse the transfer.

A memory write starts with two address bytes, high byte first. The memory pointer then advances once for every completed data byte and wraps to zero at the configured density. A memory read takes no address bytes. It continues from the current pointer, so a random read is built from a write that carries only the address, followed by a repeated start in the read direction. Register traffic uses a single address byte and never disturbs the memory pointer.

Top module: `addr_ptr_mgr`

## Requirements
- R1: After synchronous reset, both pointers are zero and the block is idle. In this state `addr_o` is 0, `valid_o` is 0 and `illegal_o` is 0.
- R2: In a memory write (`tgt_i`=0, `rd_i`=0), the first address byte is the high byte and the second is the low byte. After the low byte, the memory pointer is {high,low} with the bits at and above `MEM_AW` dropped, and `valid_o` is 1.
- R3: In the data phase of a memory transaction, each `data_done_i` advances the memory pointer by one. From 2^`MEM_AW`-1 it wraps to 0.
- R4: A memory read (`rd_i`=1) needs no address bytes. Its data phase begins at once from the retained pointer, which survives stops and new transactions.
- R5: Transactions to the register target (`tgt_i`=1) never change the memory pointer.
- R6: In a register write, the single address byte loads the register pointer when it is 00h to 18h. `addr_o` then shows it zero-extended, `valid_o` is 1 and `illegal_o` is 0.
- R7: A register address byte above 18h sets `illegal_o` and clears `valid_o`. The register pointer keeps its old value, and later `data_done_i` events in that transaction are ignored.
- R8: The register pointer also advances on each data byte. Stepping from 18h to 19h makes `illegal_o` 1 and `valid_o` 0, and the pointer does not advance further.
- R9: While the low address byte is still awaited, `valid_o` is 0. If the transaction ends after only the high byte, the memory pointer is unchanged.
- R10: `addr_byte_i` during a data phase and `data_done_i` outside a data phase have no effect on either pointer.
- R11: A start during an active transaction (a repeated start) restarts the address phase for the new target and direction.
- R12: Outside a transaction, `addr_o` shows the memory pointer and both flags are 0. A start takes priority over a stop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Slave address accepted: a transaction (or repeated start) begins |
| tgt_i | input | 1 | Target of the starting transaction: 0 memory, 1 registers |
| rd_i | input | 1 | Direction of the starting transaction: 1 read, 0 write |
| addr_byte_i | input | 1 | A byte was received while the block is in an address phase |
| data_done_i | input | 1 | A data byte finished, just before its acknowledge |
| stop_i | input | 1 | Transaction ended |
| byte_i | input | 8 | Value of the received byte, sampled with `addr_byte_i` |
| addr_o | output | 16 | Active address: register pointer during register traffic, else memory pointer |
| valid_o | output | 1 | A usable address is established for the data phase |
| illegal_o | output | 1 | Register address out of range; bus side must NACK |

## Verification
The embedded properties assume that the bus controller raises at most one of `addr_byte_i` and `data_done_i` per cycle, and that `tgt_i` and `rd_i` only mean something together with `start_i`. The stimulus drives each event as a single-cycle pulse applied at the falling edge. It never combines address and data strobes, so the phase checks and the "register traffic leaves memory alone" check see only legal event streams. Stop and data events are kept in separate cycles.

// File: rtl/addr_ptr_pkg.sv
package addr_ptr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_HI   = 3'd1,
        PH_LO   = 3'd2,
        PH_REG  = 3'd3,
        PH_DATA = 3'd4
    } phase_e;

    typedef enum logic {
        TGT_MEM = 1'b0,
        TGT_REG = 1'b1
    } target_e;

    typedef struct packed {
        logic    start;
        target_e tgt;
        logic    rd;
        logic    addr_byte;
        logic    data_done;
        logic    stop;
    } bus_evt_t;

    typedef struct packed {
        logic ld_hi;
        logic ld_mem;
        logic ld_reg;
        logic inc_mem;
        logic inc_reg;
        logic clr_err;
    } ptr_ctrl_t;

    localparam int          ADDR_W       = 16;
    localparam logic [7:0]  REG_LAST_DEF = 8'h18;

    function automatic logic reg_in_range(input logic [7:0] a, input logic [7:0] last);
        return (a <= last);
    endfunction

    function automatic phase_e entry_phase(input target_e t, input logic rd);
        if (rd)
            return PH_DATA;
        else if (t == TGT_MEM)
            return PH_HI;
        else
            return PH_REG;
    endfunction

endpackage

// File: rtl/addr_phase_fsm.sv
module addr_phase_fsm
    import addr_ptr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  bus_evt_t  evt_i,
    input  logic      reg_bad_i,
    output phase_e    phase_o,
    output target_e   tgt_o,
    output ptr_ctrl_t ctrl_o
);

    phase_e  phase_q, phase_d;
    target_e tgt_q;

    always_comb begin
        phase_d = phase_q;
        if (evt_i.start) begin
            phase_d = entry_phase(evt_i.tgt, evt_i.rd);
        end else if (evt_i.stop) begin
            phase_d = PH_IDLE;
        end else if (evt_i.addr_byte) begin
            unique case (phase_q)
                PH_HI:   phase_d = PH_LO;
                PH_LO:   phase_d = PH_DATA;
                PH_REG:  phase_d = PH_DATA;
                default: phase_d = phase_q;
            endcase
        end
    end

    always_comb begin
        ctrl_o         = '0;
        ctrl_o.clr_err = evt_i.start;
        if (!evt_i.start) begin
            unique case (phase_q)
                PH_HI:   ctrl_o.ld_hi  = evt_i.addr_byte;
                PH_LO:   ctrl_o.ld_mem = evt_i.addr_byte;
                PH_REG:  ctrl_o.ld_reg = evt_i.addr_byte;
                PH_DATA: begin
                    if (evt_i.data_done) begin
                        if (tgt_q == TGT_MEM)
                            ctrl_o.inc_mem = 1'b1;
                        else if (!reg_bad_i)
                            ctrl_o.inc_reg = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            tgt_q   <= TGT_MEM;
        end else begin
            phase_q <= phase_d;
            if (evt_i.start)
                tgt_q <= evt_i.tgt;
        end
    end

    assign phase_o = phase_q;
    assign tgt_o   = tgt_q;

    // R2: waiting for a low byte only happens in memory transactions
    p_lo_mem_only_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LO) |-> (tgt_q == TGT_MEM));

    // R12: a lone stop always returns to idle
    p_stop_idle_r12: assert property (@(posedge clk) disable iff (rst)
        (evt_i.stop && !evt_i.start) |=> (phase_q == PH_IDLE));

    // R11: a start lands in the entry phase of its target and direction
    p_restart_entry_r11: assert property (@(posedge clk) disable iff (rst)
        (evt_i.start && evt_i.rd) |=> (phase_q == PH_DATA));

endmodule

// File: rtl/mem_addr_latch.sv
module mem_addr_latch
    import addr_ptr_pkg::*;
#(
    parameter int MEM_AW = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  ptr_ctrl_t         ctrl_i,
    input  logic [7:0]        byte_i,
    output logic [MEM_AW-1:0] ptr_o
);

    localparam logic [MEM_AW-1:0] PTR_TOP = '1;

    logic [7:0]        hi_q;
    logic [MEM_AW-1:0] ptr_q;
    logic [ADDR_W-1:0] full_addr;

    assign full_addr = {hi_q, byte_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q  <= '0;
            ptr_q <= '0;
        end else begin
            if (ctrl_i.ld_hi)
                hi_q <= byte_i;
            if (ctrl_i.ld_mem)
                ptr_q <= full_addr[MEM_AW-1:0];
            else if (ctrl_i.inc_mem)
                ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

    // R3: stepping past the top address lands on zero
    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_i.inc_mem && !ctrl_i.ld_mem && ptr_q == PTR_TOP) |=> (ptr_q == '0));

    // R9: with no load and no advance the pointer holds
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_i.ld_mem && !ctrl_i.inc_mem) |=> $stable(ptr_q));

endmodule

// File: rtl/reg_ptr_unit.sv
module reg_ptr_unit
    import addr_ptr_pkg::*;
#(
    parameter logic [7:0] REG_LAST = REG_LAST_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  ptr_ctrl_t  ctrl_i,
    input  logic [7:0] byte_i,
    output logic [7:0] ptr_o,
    output logic       err_o,
    output logic       over_o
);

    localparam logic [7:0] REG_PAST = REG_LAST + 8'd1;

    logic [7:0] ptr_q;
    logic       err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (ctrl_i.clr_err)
                err_q <= 1'b0;
            if (ctrl_i.ld_reg) begin
                if (reg_in_range(byte_i, REG_LAST)) begin
                    ptr_q <= byte_i;
                    err_q <= 1'b0;
                end else begin
                    err_q <= 1'b1;
                end
            end else if (ctrl_i.inc_reg && reg_in_range(ptr_q, REG_LAST)) begin
                ptr_q <= ptr_q + 8'd1;
            end
        end
    end

    assign ptr_o  = ptr_q;
    assign err_o  = err_q;
    assign over_o = !reg_in_range(ptr_q, REG_LAST);

    // R8: the pointer never climbs more than one step past the last register
    p_ptr_bound_r8: assert property (@(posedge clk) disable iff (rst)
        ptr_q <= REG_PAST);

    // R7: a rejected address freezes the pointer
    p_err_freeze_r7: assert property (@(posedge clk) disable iff (rst)
        err_q |=> $stable(ptr_q));

endmodule

// File: rtl/addr_ptr_mgr.sv
module addr_ptr_mgr
    import addr_ptr_pkg::*;
#(
    parameter int         MEM_AW   = 13,
    parameter logic [7:0] REG_LAST = REG_LAST_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start_i,
    input  logic        tgt_i,
    input  logic        rd_i,
    input  logic        addr_byte_i,
    input  logic        data_done_i,
    input  logic        stop_i,
    input  logic [7:0]  byte_i,
    output logic [15:0] addr_o,
    output logic        valid_o,
    output logic        illegal_o
);

    bus_evt_t          evt;
    ptr_ctrl_t         ctrl;
    phase_e            phase;
    target_e           tgt;
    logic [MEM_AW-1:0] mem_ptr;
    logic [7:0]        reg_ptr;
    logic              reg_err;
    logic              reg_over;
    logic [15:0]       mem_ext;
    logic              in_xfer;

    assign evt.start     = start_i;
    assign evt.tgt       = target_e'(tgt_i);
    assign evt.rd        = rd_i;
    assign evt.addr_byte = addr_byte_i;
    assign evt.data_done = data_done_i;
    assign evt.stop      = stop_i;

    addr_phase_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt),
        .reg_bad_i (reg_err | reg_over),
        .phase_o   (phase),
        .tgt_o     (tgt),
        .ctrl_o    (ctrl)
    );

    mem_addr_latch #(.MEM_AW(MEM_AW)) u_mem (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl),
        .byte_i (byte_i),
        .ptr_o  (mem_ptr)
    );

    reg_ptr_unit #(.REG_LAST(REG_LAST)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .ctrl_i (ctrl),
        .byte_i (byte_i),
        .ptr_o  (reg_ptr),
        .err_o  (reg_err),
        .over_o (reg_over)
    );

    always_comb begin
        mem_ext             = '0;
        mem_ext[MEM_AW-1:0] = mem_ptr;
    end

    assign in_xfer   = (phase != PH_IDLE);
    assign illegal_o = in_xfer && (tgt == TGT_REG) &&
                       (reg_err || (phase == PH_DATA && reg_over));
    assign valid_o   = (phase == PH_DATA) && !illegal_o;
    assign addr_o    = (in_xfer && tgt == TGT_REG) ? {8'h00, reg_ptr} : mem_ext;

    // R5: a cycle spent on the register target leaves the memory pointer alone
    p_reg_no_mem_r5: assert property (@(posedge clk) disable iff (rst)
        (in_xfer && tgt == TGT_REG) |=> $stable(mem_ptr));

    // R12: idle means no flags
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        !in_xfer |-> (!valid_o && !illegal_o));

endmodule

// File: tb/tb_addr_ptr_mgr.sv
module tb_addr_ptr_mgr;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, tgt_i, rd_i, addr_byte_i, data_done_i, stop_i;
    logic [7:0]  byte_i;
    logic [15:0] addr_o;
    logic        valid_o, illegal_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [17:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    addr_ptr_mgr dut (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .tgt_i       (tgt_i),
        .rd_i        (rd_i),
        .addr_byte_i (addr_byte_i),
        .data_done_i (data_done_i),
        .stop_i      (stop_i),
        .byte_i      (byte_i),
        .addr_o      (addr_o),
        .valid_o     (valid_o),
        .illegal_o   (illegal_o)
    );

    task automatic compare(input logic [17:0] e, input string tag);
        checks++;
        if ({addr_o, valid_o, illegal_o} !== e) begin
            errors++;
            $display("FAIL %s: got addr=%h valid=%b illegal=%b, expected addr=%h valid=%b illegal=%b",
                     tag, addr_o, valid_o, illegal_o, e[17:2], e[1], e[0]);
        end
    endtask

    // monitor: compare one queued expectation per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [17:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compare(e, t);
        end
    end

    // driver: pulse events for one cycle, then queue the expected outputs
    task automatic step(input logic s, input logic t, input logic r, input logic ab,
                        input logic dd, input logic sp, input logic [7:0] b,
                        input logic [15:0] ea, input logic ev, input logic ei,
                        input string tag);
        @(negedge clk);
        start_i = s; tgt_i = t; rd_i = r; addr_byte_i = ab;
        data_done_i = dd; stop_i = sp; byte_i = b;
        @(posedge clk);
        #1;
        start_i = 0; addr_byte_i = 0; data_done_i = 0; stop_i = 0;
        exp_q.push_back({ea, ev, ei});
        tag_q.push_back(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        rst = 1; start_i = 0; tgt_i = 0; rd_i = 0; addr_byte_i = 0;
        data_done_i = 0; stop_i = 0; byte_i = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        compare({16'h0000, 1'b0, 1'b0}, "R1 reset state");

        // memory write: high then low, upper bits dropped (MEM_AW=13)
        step(1,0,0,0,0,0,8'h00, 16'h0000,0,0, "R9 awaiting high byte");
        step(0,0,0,1,0,0,8'hFF, 16'h0000,0,0, "R9 awaiting low byte");
        step(0,0,0,1,0,0,8'hFE, 16'h1FFE,1,0, "R2 address loaded and masked");
        step(0,0,0,0,1,0,8'h00, 16'h1FFF,1,0, "R3 advance");
        step(0,0,0,0,1,0,8'h00, 16'h0000,1,0, "R3 wrap to zero");
        step(0,0,0,1,0,0,8'h55, 16'h0000,1,0, "R10 address byte in data phase");
        step(0,0,0,0,0,1,8'h00, 16'h0000,0,0, "R12 idle after stop");

        // set 0345, then a write that carries only the high byte
        step(1,0,0,0,0,0,8'h00, 16'h0000,0,0, "R2 new write");
        step(0,0,0,1,0,0,8'h03, 16'h0000,0,0, "R9 high only");
        step(0,0,0,1,0,0,8'h45, 16'h0345,1,0, "R2 load 0345");
        step(0,0,0,0,1,0,8'h00, 16'h0346,1,0, "R3 advance");
        step(0,0,0,0,0,1,8'h00, 16'h0346,0,0, "R12 idle shows memory pointer");
        step(1,0,0,0,0,0,8'h00, 16'h0346,0,0, "R9 write start");
        step(0,0,0,1,0,0,8'h12, 16'h0346,0,0, "R9 high byte pending");
        step(0,0,0,0,1,0,8'h00, 16'h0346,0,0, "R10 data done outside data phase");
        step(0,0,0,0,0,1,8'h00, 16'h0346,0,0, "R9 pointer unchanged");
        step(1,0,1,0,0,0,8'h00, 16'h0346,1,0, "R4 read from retained pointer");
        step(0,0,0,0,1,0,8'h00, 16'h0347,1,0, "R4 read advances");

        // random read through repeated start, start beats stop
        step(1,0,0,0,0,1,8'h00, 16'h0347,0,0, "R12 start wins over stop");
        step(0,0,0,1,0,0,8'h00, 16'h0347,0,0, "R11 high byte");
        step(0,0,0,1,0,0,8'h10, 16'h0010,1,0, "R11 target address");
        step(1,0,1,0,0,0,8'h00, 16'h0010,1,0, "R11 repeated start read");
        step(0,0,0,0,1,0,8'h00, 16'h0011,1,0, "R11 read data");
        step(0,0,0,0,0,1,8'h00, 16'h0011,0,0, "R12 stop");

        // register target burst across the last register
        step(1,1,0,0,0,0,8'h00, 16'h0000,0,0, "R6 register write start");
        step(0,0,0,1,0,0,8'h17, 16'h0017,1,0, "R6 register address 17h");
        step(0,0,0,0,1,0,8'h00, 16'h0018,1,0, "R8 advance to 18h");
        step(0,0,0,0,1,0,8'h00, 16'h0019,0,1, "R8 stepped past last register");
        step(0,0,0,0,1,0,8'h00, 16'h0019,0,1, "R8 no further advance");
        step(0,0,0,0,0,1,8'h00, 16'h0011,0,0, "R5 memory pointer untouched");

        // out-of-range register address
        step(1,1,0,0,0,0,8'h00, 16'h0019,0,0, "R7 register write start");
        step(0,0,0,1,0,0,8'h20, 16'h0019,0,1, "R7 illegal address rejected");
        step(0,0,0,0,1,0,8'h00, 16'h0019,0,1, "R7 data ignored after reject");
        step(0,0,0,0,0,1,8'h00, 16'h0011,0,0, "R5 memory still 0011");

        // boundary and register read
        step(1,1,0,0,0,0,8'h00, 16'h0019,0,0, "R6 write start");
        step(0,0,0,1,0,0,8'h18, 16'h0018,1,0, "R6 last register accepted");
        step(1,1,1,0,0,0,8'h00, 16'h0018,1,0, "R11 register read restart");
        step(0,0,0,0,1,0,8'h00, 16'h0019,0,1, "R8 read steps past last");
        step(1,1,0,0,0,0,8'h00, 16'h0019,0,0, "R6 write start");
        step(0,0,0,1,0,0,8'h05, 16'h0005,1,0, "R6 register 05h");
        step(0,0,0,0,0,1,8'h00, 16'h0011,0,0, "R12 stop");
        step(1,0,1,0,0,0,8'h00, 16'h0011,1,0, "R5 memory read after register traffic");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule